// File: doc/BRIEF.md
# Serial Line Baud Measurement Unit

The unit observes an asynchronous serial receive line and gathers pulse timing statistics from which software can derive the remote sender's bit rate. While the measurement enable is held high, every accepted line transition is counted. The unit also keeps four timing results:

- the shortest completed low pulse;
- the longest completed high pulse;
- the shortest interval between two successive rising transitions;
- the shortest interval between two successive falling transitions.

All durations are in clock cycles. Noise is rejected by a programmable minimum pulse width: shorter excursions of the line are treated as though they never happened.

Software raises the enable, lets the sender transmit a known pattern, and reads the five results as plain outputs. Dropping the enable freezes the results. The next rising edge of the enable discards them and starts a fresh measurement. Turning the results into a clock divisor is left to software.

Top module: `baud_probe`

## Requirements
- R1: After reset, and one cycle after each rising edge of `meas_en`, `low_min`, `rise_min` and `fall_min` read all ones, while `high_max` and `edge_count` read zero.
- R2: A line excursion shorter than `glitch_width` clock cycles, as seen after the synchronizer, is ignored: it creates no edge and is merged into the surrounding pulse. An excursion of exactly `glitch_width` cycles is accepted. A `glitch_width` of 0 behaves as 1.
- R3: `edge_count` counts accepted transitions of both polarities since measurement start, and stops at 2^EDGE_W-1 instead of wrapping.
- R4: `low_min` holds the minimum duration of completed low pulses, measured from an accepted falling edge to the next accepted rising edge.
- R5: `high_max` holds the maximum duration of completed high pulses, measured from an accepted rising edge to the next accepted falling edge.
- R6: `rise_min` holds the minimum interval between consecutive accepted rising edges. `fall_min` does the same for consecutive accepted falling edges.
- R7: Every duration saturates at 2^CNT_W-1, so a longer pulse or interval reads exactly 2^CNT_W-1.
- R8: The pulse already in progress when measurement starts is never measured. The pulse still in progress at read time is not included either.
- R9: While `meas_en` is low, all five results hold their values and line activity has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_en | input | 1 | Measurement enable; a rising edge restarts the measurement |
| glitch_width | input | GLITCH_W | Minimum accepted pulse width in clock cycles |
| rx_in | input | 1 | Raw serial receive line, idle high, synchronized internally by two flip-flops |
| low_min | output | CNT_W | Shortest completed low pulse |
| high_max | output | CNT_W | Longest completed high pulse |
| rise_min | output | CNT_W | Shortest rising-to-rising interval |
| fall_min | output | CNT_W | Shortest falling-to-falling interval |
| edge_count | output | EDGE_W | Accepted transitions since measurement start |

## Verification
The bench builds the unit with CNT_W=10 and EDGE_W=5, keeping GLITCH_W at 8. With those widths, a 1500-cycle low pulse and a 1200-cycle high pulse both reach the duration ceiling of 1023. A train of 41 short pulses likewise pushes the edge counter past its ceiling of 31. None of this would be reachable in a short run at the default widths. Glitch widths of 0, 1 and 4 are used, which covers rejection of excursions one cycle too short, acceptance at exactly the threshold, and the zero-means-one rule.

// File: rtl/baud_probe_pkg.sv
// Package: shared types of the baud measurement unit.
// Assumes: nothing beyond IEEE 1800-2017.
package baud_probe_pkg;

    // Kind of accepted transition reported by the glitch filter
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } line_edge_e;

    // Which extreme a tracker keeps
    typedef enum logic {
        KEEP_MIN = 1'b0,
        KEEP_MAX = 1'b1
    } extreme_e;

endpackage

// File: rtl/bp_sync.sv
// Module: multi-flop synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2; the reset value equals the idle level of the line.
module bp_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{IDLE}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bp_glitch_filter.sv
// Module: minimum-width filter on a synchronized line.
// A change of the line is accepted once the new level has been present for
// max(min_width,1) consecutive cycles. Because every accepted change is
// delayed by the same amount, the spacing of accepted edges equals the
// spacing of the original transitions.
// Assumes: while active is low, the filter tracks the line and reports no edge.
module bp_glitch_filter
    import baud_probe_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          line_in,
    input  logic [GW-1:0] min_width,
    output line_edge_e    edge_kind
);
    localparam int CW = GW + 1;

    logic          level;
    logic [GW-1:0] hold_cnt;
    logic [CW-1:0] need;
    logic [CW-1:0] seen;
    logic          accept;

    // Required persistence, and persistence reached in this cycle
    always_comb begin
        need      = (min_width == '0) ? CW'(1) : {1'b0, min_width};
        seen      = {1'b0, hold_cnt} + CW'(1);
        accept    = active && (line_in != level) && (seen >= need);
        edge_kind = accept ? (level ? EDGE_FALL : EDGE_RISE) : EDGE_NONE;
    end

    // Track the filtered level and the run length of a differing input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level    <= 1'b1;
            hold_cnt <= '0;
        end else if (!active || accept) begin
            level    <= line_in;
            hold_cnt <= '0;
        end else if (line_in != level) begin
            hold_cnt <= hold_cnt + GW'(1);
        end else begin
            hold_cnt <= '0;
        end
    end
endmodule

// File: rtl/bp_span_counter.sv
// Module: saturating cycle counter measuring the time since its last restart.
// A restart loads 1, which is the first cycle of the new span, so at the next
// restart the value equals the span length in cycles.
// Assumes: clear has priority over restart; counting only while active.
module bp_span_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         active,
    input  logic         restart,
    output logic [W-1:0] span
);
    localparam logic [W-1:0] TOP = '1;

    // Count cycles, saturating at all ones
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  span <= '0;
        else if (active) begin
            if (restart)          span <= W'(1);
            else if (span != TOP) span <= span + W'(1);
        end
    end
endmodule

// File: rtl/bp_extreme.sv
// Module: keeps the minimum or maximum of the samples offered to it.
// Assumes: init has priority over take; MODE selects the comparison.
module bp_extreme
    import baud_probe_pkg::*;
#(
    parameter int       W    = 20,
    parameter extreme_e MODE = KEEP_MIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         take,
    input  logic [W-1:0] sample,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] START = {W{MODE == KEEP_MIN}};

    logic better;

    generate
        if (MODE == KEEP_MIN) begin : g_min
            assign better = sample < value;
        end else begin : g_max
            assign better = sample > value;
        end
    endgenerate

    // Load the neutral value on init, else keep the better sample
    always_ff @(posedge clk) begin
        if (!rst_n || init)    value <= START;
        else if (take && better) value <= sample;
    end
endmodule

// File: rtl/baud_probe.sv
// Module: top of the baud measurement unit.
// Synchronizes the line, filters glitches, and measures completed pulses and
// same-polarity edge intervals while meas_en is high. A rising edge of
// meas_en reinitialises every result. The first cycle with meas_en high is
// spent on that, and edges are accepted from the following cycle.
// Assumes: rx_in is idle high; results are read directly as outputs.
module baud_probe
    import baud_probe_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int EDGE_W      = 10,
    parameter int GLITCH_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_en,
    input  logic [GLITCH_W-1:0] glitch_width,
    input  logic                rx_in,
    output logic [CNT_W-1:0]    low_min,
    output logic [CNT_W-1:0]    high_max,
    output logic [CNT_W-1:0]    rise_min,
    output logic [CNT_W-1:0]    fall_min,
    output logic [EDGE_W-1:0]   edge_count
);
    localparam int               SPAN_ANY  = 0;
    localparam int               SPAN_RISE = 1;
    localparam int               SPAN_FALL = 2;
    localparam int               N_SPAN    = 3;
    localparam logic [EDGE_W-1:0] EDGE_TOP = '1;

    logic             en_q;
    logic             start;
    logic             active;
    logic             rx_sync;
    line_edge_e       ekind;
    logic             edge_rise;
    logic             edge_fall;
    logic             edge_any;
    logic [N_SPAN-1:0] restart_vec;
    logic [N_SPAN-1:0] seen_vec;
    logic [CNT_W-1:0]  span [N_SPAN];

    // Remember the enable of the previous cycle to find measurement start
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= meas_en;
    end

    assign start  = meas_en && !en_q;
    assign active = meas_en && en_q;

    bp_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_sync)
    );

    bp_glitch_filter #(.GW(GLITCH_W)) i_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .line_in   (rx_sync),
        .min_width (glitch_width),
        .edge_kind (ekind)
    );

    assign edge_rise   = (ekind == EDGE_RISE);
    assign edge_fall   = (ekind == EDGE_FALL);
    assign edge_any    = edge_rise || edge_fall;
    assign restart_vec = {edge_fall, edge_rise, edge_any};

    // One span counter per restart source: any edge, rising, falling
    generate
        for (genvar k = 0; k < N_SPAN; k++) begin : g_span
            bp_span_counter #(.W(CNT_W)) i_span (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear   (start),
                .active  (active),
                .restart (restart_vec[k]),
                .span    (span[k])
            );
        end
    endgenerate

    // Note which edge kinds have occurred, so partial spans are skipped
    always_ff @(posedge clk) begin
        if (!rst_n || start) seen_vec <= '0;
        else                 seen_vec <= seen_vec | restart_vec;
    end

    bp_extreme #(.W(CNT_W), .MODE(KEEP_MIN)) i_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start),
        .take   (edge_rise && seen_vec[SPAN_ANY]),
        .sample (span[SPAN_ANY]),
        .value  (low_min)
    );

    bp_extreme #(.W(CNT_W), .MODE(KEEP_MAX)) i_high (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start),
        .take   (edge_fall && seen_vec[SPAN_ANY]),
        .sample (span[SPAN_ANY]),
        .value  (high_max)
    );

    bp_extreme #(.W(CNT_W), .MODE(KEEP_MIN)) i_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start),
        .take   (edge_rise && seen_vec[SPAN_RISE]),
        .sample (span[SPAN_RISE]),
        .value  (rise_min)
    );

    bp_extreme #(.W(CNT_W), .MODE(KEEP_MIN)) i_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start),
        .take   (edge_fall && seen_vec[SPAN_FALL]),
        .sample (span[SPAN_FALL]),
        .value  (fall_min)
    );

    // Count accepted edges, saturating at all ones
    always_ff @(posedge clk) begin
        if (!rst_n || start)                         edge_count <= '0;
        else if (edge_any && edge_count != EDGE_TOP) edge_count <= edge_count + EDGE_W'(1);
    end
endmodule

// File: rtl/baud_probe_chk.sv
// Module: property checker for baud_probe, attached with bind below.
// Assumes: observes top-level ports only.
module baud_probe_chk #(
    parameter int CNT_W  = 20,
    parameter int EDGE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              meas_en,
    input logic [CNT_W-1:0]  low_min,
    input logic [CNT_W-1:0]  high_max,
    input logic [CNT_W-1:0]  rise_min,
    input logic [CNT_W-1:0]  fall_min,
    input logic [EDGE_W-1:0] edge_count
);
    assert_init_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_en) |=> (low_min == '1 && rise_min == '1 && fall_min == '1
                            && high_max == '0 && edge_count == '0));

    assert_edge_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && $past(meas_en)) |=>
            (edge_count == $past(edge_count) || edge_count == $past(edge_count) + EDGE_W'(1)));

    assert_low_never_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && $past(meas_en)) |=> (low_min <= $past(low_min)));

    assert_high_never_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && $past(meas_en)) |=> (high_max >= $past(high_max)));

    assert_periods_never_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && $past(meas_en)) |=>
            (rise_min <= $past(rise_min) && fall_min <= $past(fall_min)));

    assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> ($stable(low_min) && $stable(high_max) && $stable(rise_min)
                      && $stable(fall_min) && $stable(edge_count)));
endmodule

bind baud_probe baud_probe_chk #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) i_baud_probe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_en    (meas_en),
    .low_min    (low_min),
    .high_max   (high_max),
    .rise_min   (rise_min),
    .fall_min   (fall_min),
    .edge_count (edge_count)
);

// File: tb/test_baud_probe.sv
// Bench: a driver shapes pulse trains and pushes the expected results into a
// scoreboard queue; a monitor pops them at falling clock edges and compares.
module test_baud_probe;
    localparam int     CLK_PERIOD = 10;
    localparam int     CNT_W      = 10;
    localparam int     EDGE_W     = 5;
    localparam int     GLITCH_W   = 8;
    localparam longint WMAX       = (longint'(1) << CNT_W) - 1;
    localparam longint EMAX       = (longint'(1) << EDGE_W) - 1;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                meas_en;
    logic [GLITCH_W-1:0] glitch_width;
    logic                rx_in;
    logic [CNT_W-1:0]    low_min, high_max, rise_min, fall_min;
    logic [EDGE_W-1:0]   edge_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_probe #(.CNT_W(CNT_W), .EDGE_W(EDGE_W), .GLITCH_W(GLITCH_W)) i_baud_probe (
        .clk, .rst_n, .meas_en, .glitch_width, .rx_in,
        .low_min, .high_max, .rise_min, .fall_min, .edge_count
    );

    typedef struct {
        string  what;
        int     field;
        longint expv;
    } exp_t;

    exp_t   sbq[$];
    int     seg[$];
    int     total = 0;
    int     bad   = 0;
    bit     finished = 0;
    longint last_exp [5];
    longint init_exp [5];

    function automatic longint field_val(int f);
        case (f)
            0:       return longint'(low_min);
            1:       return longint'(high_max);
            2:       return longint'(rise_min);
            3:       return longint'(fall_min);
            default: return longint'(edge_count);
        endcase
    endfunction

    function automatic string field_req(int f);
        case (f)
            0:       return "R4 low_min";
            1:       return "R5 high_max";
            2:       return "R6 rise_min";
            3:       return "R6 fall_min";
            default: return "R3 edge_count";
        endcase
    endfunction

    function automatic longint cap(longint v);
        return (v > WMAX) ? WMAX : v;
    endfunction

    // Monitor: compare queued expectations with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() != 0) begin
                exp_t it;
                it = sbq.pop_front();
                total++;
                if (field_val(it.field) != it.expv) begin
                    bad++;
                    $display("FAIL %s act=%0d exp=%0d", it.what, field_val(it.field), it.expv);
                end
            end
        end
    end

    // Driver side: push the five expected results, wait for the monitor
    task automatic expect5(string tag, longint e [5]);
        for (int f = 0; f < 5; f++) begin
            exp_t it;
            it.what  = {tag, " / ", field_req(f)};
            it.field = f;
            it.expv  = e[f];
            sbq.push_back(it);
        end
        wait (sbq.size() == 0);
    endtask

    // Expected results of the pulse train in seg (all pulses accepted)
    task automatic model(bit l0, output longint e [5]);
        longint lo  = WMAX;
        longint hi  = 0;
        longint rmn = WMAX;
        longint fmn = WMAX;
        longint ec  = 0;
        int     n   = seg.size();
        for (int i = 0; i < n; i++) begin
            bit lv;
            lv = l0 ^ i[0];
            if (ec < EMAX) ec++;
            if (i < n - 1) begin
                if (!lv) lo = (cap(seg[i]) < lo) ? cap(seg[i]) : lo;
                else     hi = (cap(seg[i]) > hi) ? cap(seg[i]) : hi;
            end
            if (i + 2 < n) begin
                longint p;
                p = cap(longint'(seg[i]) + longint'(seg[i+1]));
                if (lv) rmn = (p < rmn) ? p : rmn;
                else    fmn = (p < fmn) ? p : fmn;
            end
        end
        e[0] = lo; e[1] = hi; e[2] = rmn; e[3] = fmn; e[4] = ec;
    endtask

    // Restart measurement with the line at ~l0, then drive the segments
    task automatic drive(int g, bit l0);
        @(negedge clk);
        meas_en      = 1'b0;
        glitch_width = GLITCH_W'(g);
        rx_in        = ~l0;
        repeat (g + 6) @(negedge clk);
        meas_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < seg.size(); i++) begin
            rx_in = l0 ^ i[0];
            repeat (seg[i]) @(negedge clk);
        end
    endtask

    task automatic run_case(string tag, int g, bit l0);
        longint e [5];
        drive(g, l0);
        model(l0, e);
        last_exp = e;
        expect5(tag, e);
    endtask

    initial begin
        longint e [5];
        init_exp[0] = WMAX; init_exp[1] = 0; init_exp[2] = WMAX;
        init_exp[3] = WMAX; init_exp[4] = 0;
        rst_n = 1'b0; meas_en = 1'b0; glitch_width = GLITCH_W'(1); rx_in = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect5("R1 reset values", init_exp);

        seg = '{5, 7, 3, 9, 4, 2, 6, 40};
        run_case("R4 R5 R6 R8 mixed train", 1, 1'b0);

        seg = '{4, 4, 4, 4, 30};
        run_case("R2 pulses exactly at glitch width", 4, 1'b0);

        // R2: 2- and 3-cycle excursions under a width of 4 merge into neighbours
        seg = '{10, 2, 8, 12, 3, 9, 40};
        drive(4, 1'b0);
        e[0] = 20; e[1] = 24; e[2] = WMAX; e[3] = 44; e[4] = 3;
        last_exp = e;
        expect5("R2 glitches rejected", e);

        seg = '{2, 3, 2, 20};
        run_case("R2 zero glitch width acts as one", 0, 1'b0);

        seg = '{6, 4, 30};
        run_case("R8 line low at start", 1, 1'b1);

        seg = '{1500, 5, 30};
        run_case("R7 long low saturates", 1, 1'b0);

        seg = '{20, 1200, 8, 50};
        run_case("R7 long high saturates", 1, 1'b0);

        seg.delete();
        for (int i = 0; i < 40; i++) seg.push_back(3);
        seg.push_back(20);
        run_case("R3 R7 edge counter saturates", 1, 1'b0);

        // R9: activity with enable low leaves every result unchanged
        @(negedge clk);
        meas_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rx_in = i[0];
            repeat (5) @(negedge clk);
        end
        rx_in = 1'b1;
        repeat (10) @(negedge clk);
        expect5("R9 hold while disabled", last_exp);

        // R1: a new rising edge of the enable reinitialises all results
        meas_en = 1'b1;
        repeat (2) @(negedge clk);
        expect5("R1 restart values", init_exp);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule